// File: doc/BRIEF.md
# Reorder Window for In-Order Retirement

The reorder window keeps in-flight instructions in program order so that they may finish in any order while their effects reach architectural state strictly in order. Decode reserves an entry and receives the entry index as a tag. A functional unit later writes its result, an exception flag and, for a store, the address and data into the tagged entry. Each cycle the oldest entry is examined. If it has finished cleanly, it is released to the register-file write port, or to the memory write port for a store. If it finished with a fault, it is not released. The whole window is discarded instead, and fetch is steered to a fixed handler address while the faulting PC is held on a dedicated output.

Decode can also ask about a source register at the same time as it reads the register file. The window reports whether an in-flight instruction will write that register. If it will, the window gives the youngest such producer's value when that value is ready, or the producer's tag when it is not. The register file, functional units, fetch and memory are outside the block. The depth must be a power of two.

The control state machine has two states. RUN is the normal state, in which allocation, completion, lookup and retirement take place. FLUSH lasts one cycle after a fault is found at the head. The transition RUN→FLUSH is taken when the head entry is valid, done and faulting. FLUSH→RUN is always taken on the next cycle.

Top module: `reorder_window`

## Requirements
- R1: After reset the window is empty: `alloc_ready_o`=1, `alloc_tag_o`=0, both retire write enables are 0, `flush_o`=0 and `lkp_hit_o`=0.
- R2: An accepted allocation is given the tag shown on `alloc_tag_o` during that cycle. Tags go 0,1,2,… and wrap modulo DEPTH. After reset or a flush they start again at 0.
- R3: Completions may arrive for any tag in any order. Entries retire only in allocation order, at most one per cycle, and only once completed without fault. A retiring non-store raises `ret_reg_we_o` with its destination ID and result value, visible in the cycle after the completion that makes it eligible.
- R4: A retiring store (`alloc_store_i`=1 at allocation) raises `ret_mem_we_o` with the store address and data from its completion, and it does not raise `ret_reg_we_o`.
- R5: While DEPTH entries are held, `alloc_ready_o` is 0 and an asserted `alloc_valid_i` adds no entry.
- R6: A lookup of register ID X hits only valid non-store entries whose destination is X, and the youngest such entry is reported. If it has completed, `lkp_ready_o`=1 and `lkp_value_o` is its result. If it has not, `lkp_ready_o`=0 and `lkp_tag_o` is its index.
- R7: A faulting head entry is not retired. One cycle after it appears at the head, `flush_o` is 1 for exactly one cycle, with `redirect_pc_o`=HANDLER_PC and `epc_o` holding the faulting PC. Every entry is discarded.
- R8: While `flush_o` is 1 (state FLUSH), `alloc_ready_o` is 0 and allocations and completions are ignored. On the next cycle the state returns to RUN with an empty window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid_i | input | 1 | Decode requests an entry |
| alloc_rd_i | input | REG_W | Destination register ID |
| alloc_pc_i | input | PC_W | PC of the instruction |
| alloc_store_i | input | 1 | Instruction is a store |
| alloc_ready_o | output | 1 | An entry can be accepted this cycle |
| alloc_tag_o | output | IDX_W | Tag the next accepted entry receives |
| cmp_valid_i | input | 1 | Completion write strobe |
| cmp_tag_i | input | IDX_W | Entry being completed |
| cmp_value_i | input | DATA_W | Result value |
| cmp_exc_i | input | 1 | Instruction faulted |
| cmp_st_addr_i | input | DATA_W | Store address |
| cmp_st_data_i | input | DATA_W | Store data |
| lkp_reg_i | input | REG_W | Source register ID looked up |
| lkp_hit_o | output | 1 | An in-flight producer exists |
| lkp_ready_o | output | 1 | Producer's result is available |
| lkp_value_o | output | DATA_W | Producer's result (0 unless ready) |
| lkp_tag_o | output | IDX_W | Producer's entry index |
| ret_reg_we_o | output | 1 | Register-file write at retirement |
| ret_rd_o | output | REG_W | Register written |
| ret_value_o | output | DATA_W | Value written |
| ret_mem_we_o | output | 1 | Memory write at retirement |
| ret_st_addr_o | output | DATA_W | Store address |
| ret_st_data_o | output | DATA_W | Store data |
| flush_o | output | 1 | Window discarded, redirect fetch |
| redirect_pc_o | output | PC_W | Handler address |
| epc_o | output | PC_W | PC of the faulting instruction |

## Verification
A corrupted head pointer or done bit shows up in the cycle after the relevant completion. In that case a result appears on the retire port out of allocation order, or fails to appear in the expected cycle. A wrong occupancy count shows up in the cycle after the sixteenth allocation, either as `alloc_ready_o` staying high or as a seventeenth retirement once the window drains. Bad youngest-match selection shows up combinationally on the lookup port in the same cycle the query is applied. A faulty flush path shows up one cycle after the fault reaches the head, as a missing or misaligned `flush_o`/`epc_o` pair, or as a flushed entry that later retires or still hits a lookup.

// File: rtl/rw_pkg.sv
package rw_pkg;
    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_FLUSH = 1'b1
    } rw_state_e;
endpackage

// File: rtl/rw_ctrl.sv
module rw_ctrl #(
    parameter int PC_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              head_valid,
    input  logic              head_done,
    input  logic              head_exc,
    input  logic [PC_W-1:0]   head_pc,
    input  logic              full,
    output rw_pkg::rw_state_e state,
    output logic              alloc_ok,
    output logic              cmp_ok,
    output logic              retire,
    output logic              clear,
    output logic              flush,
    output logic [PC_W-1:0]   epc
);
    import rw_pkg::*;

    rw_state_e state_q, state_d;
    logic      fault;

    assign fault = head_valid && head_done && head_exc;
    assign state = state_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (fault) state_d = ST_FLUSH;
            ST_FLUSH: state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    // faulting PC captured on the edge that enters FLUSH
    always_ff @(posedge clk) begin
        if (!rst_n)                           epc <= '0;
        else if (state_q == ST_RUN && fault)  epc <= head_pc;
    end

    // outputs
    always_comb begin
        alloc_ok = 1'b0;
        cmp_ok   = 1'b0;
        retire   = 1'b0;
        clear    = 1'b0;
        flush    = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                alloc_ok = !full;
                cmp_ok   = 1'b1;
                retire   = head_valid && head_done && !head_exc;
                clear    = fault;
            end
            ST_FLUSH: begin
                flush = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rw_ptrs.sv
module rw_ptrs #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             clear,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic [CNT_W-1:0] occ,
    output logic             full
);
    assign full = (occ == CNT_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            head <= '0;
            tail <= '0;
            occ  <= '0;
        end else begin
            if (push) tail <= tail + 1'b1;
            if (pop)  head <= head + 1'b1;
            occ <= occ + CNT_W'(push) - CNT_W'(pop);
        end
    end
endmodule

// File: rtl/rw_entries.sv
module rw_entries #(
    parameter int DEPTH  = 16,
    parameter int REG_W  = 5,
    parameter int DATA_W = 32,
    parameter int PC_W   = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic                         wr_alloc,
    input  logic [IDX_W-1:0]             alloc_idx,
    input  logic [REG_W-1:0]             alloc_rd,
    input  logic [PC_W-1:0]              alloc_pc,
    input  logic                         alloc_store,
    input  logic                         wr_cmp,
    input  logic [IDX_W-1:0]             cmp_idx,
    input  logic [DATA_W-1:0]            cmp_value,
    input  logic                         cmp_exc,
    input  logic [DATA_W-1:0]            cmp_addr,
    input  logic [DATA_W-1:0]            cmp_data,
    input  logic                         wr_retire,
    input  logic [IDX_W-1:0]             head,
    output logic [DEPTH-1:0]             valid_v,
    output logic [DEPTH-1:0]             done_v,
    output logic [DEPTH-1:0]             store_v,
    output logic [DEPTH-1:0][REG_W-1:0]  rd_v,
    output logic [DEPTH-1:0][DATA_W-1:0] value_v,
    output logic                         h_exc,
    output logic [PC_W-1:0]              h_pc,
    output logic [DATA_W-1:0]            h_addr,
    output logic [DATA_W-1:0]            h_data
);
    logic [DEPTH-1:0]             exc_q;
    logic [DEPTH-1:0][PC_W-1:0]   pc_q;
    logic [DEPTH-1:0][DATA_W-1:0] addr_q;
    logic [DEPTH-1:0][DATA_W-1:0] data_q;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n || clear) begin
                    valid_v[g] <= 1'b0;
                    done_v[g]  <= 1'b0;
                    exc_q[g]   <= 1'b0;
                    store_v[g] <= 1'b0;
                    rd_v[g]    <= '0;
                    value_v[g] <= '0;
                    pc_q[g]    <= '0;
                    addr_q[g]  <= '0;
                    data_q[g]  <= '0;
                end else begin
                    if (wr_alloc && alloc_idx == IDX_W'(g)) begin
                        valid_v[g] <= 1'b1;
                        done_v[g]  <= 1'b0;
                        exc_q[g]   <= 1'b0;
                        store_v[g] <= alloc_store;
                        rd_v[g]    <= alloc_rd;
                        pc_q[g]    <= alloc_pc;
                    end
                    if (wr_cmp && cmp_idx == IDX_W'(g) && valid_v[g]) begin
                        done_v[g]  <= 1'b1;
                        exc_q[g]   <= cmp_exc;
                        value_v[g] <= cmp_value;
                        addr_q[g]  <= cmp_addr;
                        data_q[g]  <= cmp_data;
                    end
                    if (wr_retire && head == IDX_W'(g)) begin
                        valid_v[g] <= 1'b0;
                    end
                end
            end
        end
    endgenerate

    assign h_exc  = exc_q[head];
    assign h_pc   = pc_q[head];
    assign h_addr = addr_q[head];
    assign h_data = data_q[head];
endmodule

// File: rtl/rw_lookup.sv
module rw_lookup #(
    parameter int DEPTH  = 16,
    parameter int REG_W  = 5,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]             valid_v,
    input  logic [DEPTH-1:0]             done_v,
    input  logic [DEPTH-1:0]             store_v,
    input  logic [DEPTH-1:0][REG_W-1:0]  rd_v,
    input  logic [DEPTH-1:0][DATA_W-1:0] value_v,
    input  logic [IDX_W-1:0]             head,
    input  logic [REG_W-1:0]             q_reg,
    output logic                         hit,
    output logic                         ready,
    output logic [DATA_W-1:0]            value,
    output logic [IDX_W-1:0]             tag
);
    logic [IDX_W-1:0] idx;

    // scan oldest to youngest; the last match is the youngest producer
    always_comb begin
        hit   = 1'b0;
        ready = 1'b0;
        value = '0;
        tag   = '0;
        idx   = head;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head + IDX_W'(k);
            if (valid_v[idx] && !store_v[idx] && rd_v[idx] == q_reg) begin
                hit   = 1'b1;
                ready = done_v[idx];
                value = done_v[idx] ? value_v[idx] : '0;
                tag   = idx;
            end
        end
    end
endmodule

// File: rtl/reorder_window.sv
module reorder_window #(
    parameter int DEPTH  = 16,
    parameter int REG_W  = 5,
    parameter int DATA_W = 32,
    parameter int PC_W   = 32,
    parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0080,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid_i,
    input  logic [REG_W-1:0]  alloc_rd_i,
    input  logic [PC_W-1:0]   alloc_pc_i,
    input  logic              alloc_store_i,
    output logic              alloc_ready_o,
    output logic [IDX_W-1:0]  alloc_tag_o,
    input  logic              cmp_valid_i,
    input  logic [IDX_W-1:0]  cmp_tag_i,
    input  logic [DATA_W-1:0] cmp_value_i,
    input  logic              cmp_exc_i,
    input  logic [DATA_W-1:0] cmp_st_addr_i,
    input  logic [DATA_W-1:0] cmp_st_data_i,
    input  logic [REG_W-1:0]  lkp_reg_i,
    output logic              lkp_hit_o,
    output logic              lkp_ready_o,
    output logic [DATA_W-1:0] lkp_value_o,
    output logic [IDX_W-1:0]  lkp_tag_o,
    output logic              ret_reg_we_o,
    output logic [REG_W-1:0]  ret_rd_o,
    output logic [DATA_W-1:0] ret_value_o,
    output logic              ret_mem_we_o,
    output logic [DATA_W-1:0] ret_st_addr_o,
    output logic [DATA_W-1:0] ret_st_data_o,
    output logic              flush_o,
    output logic [PC_W-1:0]   redirect_pc_o,
    output logic [PC_W-1:0]   epc_o
);
    rw_pkg::rw_state_e state;

    logic [IDX_W-1:0] head, tail;
    logic [CNT_W-1:0] occ;
    logic full, alloc_ok, cmp_ok, retire, clear;
    logic push;

    logic [DEPTH-1:0]             valid_v, done_v, store_v;
    logic [DEPTH-1:0][REG_W-1:0]  rd_v;
    logic [DEPTH-1:0][DATA_W-1:0] value_v;
    logic                         h_exc;
    logic [PC_W-1:0]              h_pc;

    assign push = alloc_valid_i && alloc_ok;

    rw_ctrl #(.PC_W(PC_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_valid (valid_v[head]),
        .head_done  (done_v[head]),
        .head_exc   (h_exc),
        .head_pc    (h_pc),
        .full       (full),
        .state      (state),
        .alloc_ok   (alloc_ok),
        .cmp_ok     (cmp_ok),
        .retire     (retire),
        .clear      (clear),
        .flush      (flush_o),
        .epc        (epc_o)
    );

    rw_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (retire),
        .clear (clear),
        .head  (head),
        .tail  (tail),
        .occ   (occ),
        .full  (full)
    );

    rw_entries #(
        .DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .PC_W(PC_W)
    ) u_entries (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear),
        .wr_alloc    (push),
        .alloc_idx   (tail),
        .alloc_rd    (alloc_rd_i),
        .alloc_pc    (alloc_pc_i),
        .alloc_store (alloc_store_i),
        .wr_cmp      (cmp_valid_i && cmp_ok),
        .cmp_idx     (cmp_tag_i),
        .cmp_value   (cmp_value_i),
        .cmp_exc     (cmp_exc_i),
        .cmp_addr    (cmp_st_addr_i),
        .cmp_data    (cmp_st_data_i),
        .wr_retire   (retire),
        .head        (head),
        .valid_v     (valid_v),
        .done_v      (done_v),
        .store_v     (store_v),
        .rd_v        (rd_v),
        .value_v     (value_v),
        .h_exc       (h_exc),
        .h_pc        (h_pc),
        .h_addr      (ret_st_addr_o),
        .h_data      (ret_st_data_o)
    );

    rw_lookup #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) u_lookup (
        .valid_v (valid_v),
        .done_v  (done_v),
        .store_v (store_v),
        .rd_v    (rd_v),
        .value_v (value_v),
        .head    (head),
        .q_reg   (lkp_reg_i),
        .hit     (lkp_hit_o),
        .ready   (lkp_ready_o),
        .value   (lkp_value_o),
        .tag     (lkp_tag_o)
    );

    assign alloc_ready_o = alloc_ok;
    assign alloc_tag_o   = tail;
    assign ret_reg_we_o  = retire && !store_v[head];
    assign ret_mem_we_o  = retire &&  store_v[head];
    assign ret_rd_o      = rd_v[head];
    assign ret_value_o   = value_v[head];
    assign redirect_pc_o = HANDLER_PC;
endmodule

// File: rtl/rw_checker.sv
module rw_checker #(
    parameter int DEPTH = 16,
    parameter int PC_W  = 32,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_ready_o,
    input logic             flush_o,
    input logic             ret_reg_we_o,
    input logic             ret_mem_we_o,
    input logic             lkp_hit_o,
    input logic             lkp_ready_o,
    input logic [PC_W-1:0]  epc_o,
    input logic [CNT_W-1:0] occ
);
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == CNT_W'(DEPTH)) |-> !alloc_ready_o);

    a_r5_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH));

    a_r3_one_port: assert property (@(posedge clk) disable iff (!rst_n)
        !(ret_reg_we_o && ret_mem_we_o));

    a_r6_ready_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_ready_o |-> lkp_hit_o);

    a_r7_flush_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> !flush_o);

    a_r7_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> (occ == '0) && !lkp_hit_o && !ret_reg_we_o && !ret_mem_we_o);

    a_r7_epc_held: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> $stable(epc_o));

    a_r8_no_alloc_in_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> !alloc_ready_o);
endmodule

bind reorder_window rw_checker #(.DEPTH(DEPTH), .PC_W(PC_W)) u_rw_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .alloc_ready_o (alloc_ready_o),
    .flush_o       (flush_o),
    .ret_reg_we_o  (ret_reg_we_o),
    .ret_mem_we_o  (ret_mem_we_o),
    .lkp_hit_o     (lkp_hit_o),
    .lkp_ready_o   (lkp_ready_o),
    .epc_o         (epc_o),
    .occ           (occ)
);

// File: tb/test_reorder_window.sv
module test_reorder_window;
    localparam int DEPTH = 16;
    localparam logic [31:0] HANDLER = 32'h0000_0080;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid_i = 1'b0;
    logic [4:0]  alloc_rd_i = '0;
    logic [31:0] alloc_pc_i = '0;
    logic        alloc_store_i = 1'b0;
    logic        alloc_ready_o;
    logic [3:0]  alloc_tag_o;
    logic        cmp_valid_i = 1'b0;
    logic [3:0]  cmp_tag_i = '0;
    logic [31:0] cmp_value_i = '0;
    logic        cmp_exc_i = 1'b0;
    logic [31:0] cmp_st_addr_i = '0;
    logic [31:0] cmp_st_data_i = '0;
    logic [4:0]  lkp_reg_i = '0;
    logic        lkp_hit_o, lkp_ready_o;
    logic [31:0] lkp_value_o;
    logic [3:0]  lkp_tag_o;
    logic        ret_reg_we_o, ret_mem_we_o;
    logic [4:0]  ret_rd_o;
    logic [31:0] ret_value_o, ret_st_addr_o, ret_st_data_o;
    logic        flush_o;
    logic [31:0] redirect_pc_o, epc_o;

    int checks = 0;
    int errors = 0;
    int mtail  = 0;

    always #10 clk = ~clk;

    reorder_window #(.HANDLER_PC(HANDLER)) i_reorder_window (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
        alloc_valid_i = 1'b0;
        cmp_valid_i   = 1'b0;
        cmp_exc_i     = 1'b0;
    endtask

    task automatic do_alloc(input logic [4:0] rd, input logic [31:0] pc, input logic st);
        chk(alloc_tag_o == 4'(mtail), "R2 alloc tag", 32'(alloc_tag_o), 32'(mtail));
        alloc_valid_i = 1'b1; alloc_rd_i = rd; alloc_pc_i = pc; alloc_store_i = st;
        mtail = (mtail + 1) % DEPTH;
    endtask

    task automatic do_cmp(input logic [3:0] t, input logic [31:0] v, input logic e,
                          input logic [31:0] a, input logic [31:0] d);
        cmp_valid_i = 1'b1; cmp_tag_i = t; cmp_value_i = v; cmp_exc_i = e;
        cmp_st_addr_i = a; cmp_st_data_i = d;
    endtask

    typedef struct packed {
        logic [1:0]  op;     // 0 idle, 1 alloc, 2 complete
        logic [3:0]  tag;
        logic [4:0]  rd;
        logic [31:0] dat;    // pc for alloc, value for complete
        logic        we;
        logic [4:0]  erd;
        logic [31:0] eval;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{2'd1, 4'd0, 5'd3, 32'h100, 1'b0, 5'd0, 32'h0},
        '{2'd1, 4'd0, 5'd5, 32'h104, 1'b0, 5'd0, 32'h0},
        '{2'd1, 4'd0, 5'd3, 32'h108, 1'b0, 5'd0, 32'h0},
        '{2'd2, 4'd2, 5'd0, 32'hAA,  1'b0, 5'd0, 32'h0},
        '{2'd2, 4'd1, 5'd0, 32'hBB,  1'b0, 5'd0, 32'h0},
        '{2'd2, 4'd0, 5'd0, 32'hCC,  1'b1, 5'd3, 32'hCC},
        '{2'd0, 4'd0, 5'd0, 32'h0,   1'b1, 5'd5, 32'hBB},
        '{2'd0, 4'd0, 5'd0, 32'h0,   1'b1, 5'd3, 32'hAA},
        '{2'd0, 4'd0, 5'd0, 32'h0,   1'b0, 5'd0, 32'h0}
    };

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        lkp_reg_i = 5'd3;
        // R1 reset state
        chk(alloc_ready_o == 1'b1, "R1 ready", 32'(alloc_ready_o), 1);
        chk(alloc_tag_o == 4'd0, "R1 tag", 32'(alloc_tag_o), 0);
        chk({ret_reg_we_o, ret_mem_we_o, flush_o, lkp_hit_o} == 4'b0, "R1 idle outputs",
            32'({ret_reg_we_o, ret_mem_we_o, flush_o, lkp_hit_o}), 0);

        // R3 out-of-order completion, in-order retirement (vector table)
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].op == 2'd1) do_alloc(VEC[i].rd, VEC[i].dat, 1'b0);
            else if (VEC[i].op == 2'd2) do_cmp(VEC[i].tag, VEC[i].dat, 1'b0, 0, 0);
            step();
            chk(ret_reg_we_o == VEC[i].we, "R3 retire strobe", 32'(ret_reg_we_o), 32'(VEC[i].we));
            if (VEC[i].we) begin
                chk(ret_rd_o == VEC[i].erd, "R3 retire rd", 32'(ret_rd_o), 32'(VEC[i].erd));
                chk(ret_value_o == VEC[i].eval, "R3 retire value", ret_value_o, VEC[i].eval);
            end
        end

        // R6 lookup: youngest producer, tag when pending, value when ready
        do_alloc(5'd7, 32'h300, 1'b0); step();
        do_alloc(5'd7, 32'h304, 1'b0); step();
        lkp_reg_i = 5'd7; #1;
        chk(lkp_hit_o && !lkp_ready_o, "R6 pending hit", 32'({lkp_hit_o, lkp_ready_o}), 32'b10);
        chk(lkp_tag_o == 4'd4, "R6 youngest tag", 32'(lkp_tag_o), 4);
        lkp_reg_i = 5'd12; #1;
        chk(!lkp_hit_o, "R6 miss", 32'(lkp_hit_o), 0);
        lkp_reg_i = 5'd7;
        do_cmp(4'd4, 32'h55, 1'b0, 0, 0); step();
        chk(lkp_ready_o && lkp_value_o == 32'h55, "R6 ready value", lkp_value_o, 32'h55);
        do_cmp(4'd3, 32'h44, 1'b0, 0, 0); step();
        chk(ret_reg_we_o && ret_value_o == 32'h44, "R3 older first", ret_value_o, 32'h44);
        step();
        chk(ret_reg_we_o && ret_value_o == 32'h55, "R3 younger next", ret_value_o, 32'h55);
        step();

        // R4 store retirement
        do_alloc(5'd0, 32'h400, 1'b1); step();
        lkp_reg_i = 5'd0; #1;
        chk(!lkp_hit_o, "R6 store not a producer", 32'(lkp_hit_o), 0);
        do_cmp(4'd5, 32'h0, 1'b0, 32'h8000, 32'h1234); step();
        chk(ret_mem_we_o && !ret_reg_we_o, "R4 mem strobe", 32'({ret_mem_we_o, ret_reg_we_o}), 32'b10);
        chk(ret_st_addr_o == 32'h8000, "R4 store addr", ret_st_addr_o, 32'h8000);
        chk(ret_st_data_o == 32'h1234, "R4 store data", ret_st_data_o, 32'h1234);
        step();

        // R5 full window
        begin
            int base;
            int nret;
            int bad;
            base = mtail;
            for (int k = 0; k < DEPTH; k++) begin
                do_alloc(5'd8, 32'h500 + 32'(k), 1'b0); step();
            end
            chk(alloc_ready_o == 1'b0, "R5 full stalls", 32'(alloc_ready_o), 0);
            alloc_valid_i = 1'b1; alloc_rd_i = 5'd9; alloc_pc_i = 32'h5FF; alloc_store_i = 1'b0;
            step();
            nret = 0; bad = 0;
            for (int k = DEPTH - 1; k >= 0; k--) begin
                do_cmp(4'((base + k) % DEPTH), 32'h1000 + 32'(k), 1'b0, 0, 0);
                step();
            end
            for (int c = 0; c < DEPTH + 4; c++) begin
                if (ret_reg_we_o) begin
                    if (ret_rd_o != 5'd8 || ret_value_o != 32'h1000 + 32'(nret)) bad++;
                    nret++;
                end
                step();
            end
            chk(nret == DEPTH, "R5 extra alloc ignored", 32'(nret), 32'(DEPTH));
            chk(bad == 0, "R3 full-window order", 32'(bad), 0);
        end

        // R7 fault at head, R8 flush cycle
        do_alloc(5'd1, 32'h200, 1'b0); step();
        do_alloc(5'd2, 32'h204, 1'b0); step();
        do_alloc(5'd3, 32'h208, 1'b0); step();
        do_cmp(4'((mtail + DEPTH - 2) % DEPTH), 32'h22, 1'b1, 0, 0); step();
        do_cmp(4'((mtail + DEPTH - 1) % DEPTH), 32'h33, 1'b0, 0, 0); step();
        do_cmp(4'((mtail + DEPTH - 3) % DEPTH), 32'h11, 1'b0, 0, 0); step();
        chk(ret_reg_we_o && ret_rd_o == 5'd1, "R3 pre-fault retire", 32'(ret_rd_o), 1);
        step();
        chk(!ret_reg_we_o && !flush_o, "R7 fault not retired", 32'({ret_reg_we_o, flush_o}), 0);
        step();
        lkp_reg_i = 5'd3; #1;
        chk(flush_o == 1'b1, "R7 flush", 32'(flush_o), 1);
        chk(epc_o == 32'h204, "R7 epc", epc_o, 32'h204);
        chk(redirect_pc_o == HANDLER, "R7 redirect", redirect_pc_o, HANDLER);
        chk(!lkp_hit_o, "R7 younger discarded", 32'(lkp_hit_o), 0);
        chk(!alloc_ready_o, "R8 no alloc in flush", 32'(alloc_ready_o), 0);
        alloc_valid_i = 1'b1; alloc_rd_i = 5'd4; alloc_pc_i = 32'h600; alloc_store_i = 1'b0;
        step();
        mtail = 0;
        lkp_reg_i = 5'd4; #1;
        chk(!flush_o && alloc_ready_o, "R8 back to run", 32'({flush_o, alloc_ready_o}), 32'b01);
        chk(alloc_tag_o == 4'd0 && !lkp_hit_o, "R8 flush-cycle alloc ignored",
            32'({alloc_tag_o, lkp_hit_o}), 0);
        step();
        chk(!ret_reg_we_o && !flush_o, "R7 nothing retires after flush",
            32'({ret_reg_we_o, flush_o}), 0);
        do_alloc(5'd6, 32'h700, 1'b0); step();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule